// File: doc/BRIEF.md
# Bay Power and Hot-Swap Status Registers

This block is the register file that a chassis midplane presents to its control processor for seven adapter bays. Software reads a power-good word built on the fly from the bay-present inputs. It keeps a free 32-bit control word. It collects hot-insertion and SRAM-error events in a sticky register that software clears by writing ones. It also reads a management-cause word that is filtered by live bay power, so a bay with no adapter is never reported as a source.

Two level interrupt lines leave the block. One is for insertion and error events and one is for management events. Each is raised by its event inputs and dropped by a software access to the matching register. The bus is a byte-offset register port with separate read and write strobes. Read data is registered and appears in the cycle after the read strobe.

Top module: `bay_pwr_hotswap_regs`

## Requirements
- R1: Out of reset, rdata_o, the control word and the event register are 0, and both interrupt outputs are low.
- R2: A read strobe at offset 0x50 loads rdata_o at the next clock edge with the power word from the current bay_present_i. Bay 0 always sets bit 1 (3.3 V) and bit 2 (5 V). bay_present_i[0] is ignored. Bay k (1..6), when present, sets a 5 V/3.3 V bit pair: bay1 9/10, bay2 13/14, bay3 25/26, bay4 17/18, bay5 29/30, bay6 21/22. All other bits are 0. rdata_o holds its value while no read is made.
- R3: Offset 0x58 is a 32-bit control word that returns the last value written.
- R4: Offset 0x70 reads the event register. Bit 7 is set by sram_err_i. Bit k (k = 1..6) is set by ins_evt_i[k-1], the event for slot k. Bits 0 and 8..31 read 0.
- R5: A write to 0x70 clears every event bit whose written data bit is 1 and leaves the others unchanged.
- R6: An event input that is high in the same cycle as a clearing write to 0x70 leaves its bit set.
- R7: ins_irq_o rises in the cycle after any event input is high. A read or write of 0x70 with no event input high in that cycle lowers it in the next cycle.
- R8: A read of 0x40 returns the power word ANDed with 0x66666600.
- R9: mgmt_irq_o rises in the cycle after mgmt_evt_i. A read of 0x40 lowers it unless mgmt_evt_i is high in the same cycle.
- R10: Offset 0x48 reads 0xFFFFFFFF. Offset 0x78 reads 0 and ignores writes. Any other offset reads 0.
- R11: A write to 0x50 has no effect on what 0x50 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| bay_present_i | input | 7 | Adapter present, one bit per bay |
| ins_evt_i | input | 6 | Insertion event pulses, slots 1..6 |
| sram_err_i | input | 1 | SRAM error pulse |
| mgmt_evt_i | input | 1 | Management event |
| ins_irq_o | output | 1 | Insertion/error interrupt |
| mgmt_irq_o | output | 1 | Management interrupt |

## Verification
The bench builds the block with its default parameters: seven bays, 8-bit offsets and 32-bit data. These are the only values for which the scattered power-bit layout and the slot-to-bit event order are defined. With them, every single-bay presence pattern, the all-present and alternating patterns, and the bay-0 presence bit can each be read through both the raw and the masked power offsets. The collisions between an event and a clear, or between an event and an acknowledge, are driven in the same cycle for both interrupt lines.

// File: rtl/bay_regs_pkg.sv
package bay_regs_pkg;
  localparam int unsigned NUM_BAYS = 7;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EVT_W    = NUM_BAYS + 1;  // bit 0 spare, slots 1..6, SRAM error on top

  localparam logic [ADDR_W-1:0] OFS_MGMT  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_ONES  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_PWR   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_EVT   = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_ERREN = 8'h78;

  localparam logic [DATA_W-1:0] MGMT_MASK = 32'h6666_6600;

  // 5 V good bit of each bay; software decodes this layout
  function automatic int unsigned pwr5_pos(int unsigned bay);
    case (bay)
      0:       return 2;
      1:       return 9;
      2:       return 13;
      3:       return 25;
      4:       return 17;
      5:       return 29;
      6:       return 21;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned pwr3_pos(int unsigned bay);
    return (bay == 0) ? 1 : pwr5_pos(bay) + 1;
  endfunction
endpackage

// File: rtl/bay_pwr_map.sv
module bay_pwr_map
  import bay_regs_pkg::*;
#(
  parameter int unsigned BAYS  = NUM_BAYS,
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [BAYS-1:0]  present_i,
  output logic [WIDTH-1:0] pwr_o
);
  logic [BAYS-1:0] powered;

  // bay 0 is hard-wired powered
  assign powered[0] = 1'b1;
  generate
    for (genvar b = 1; b < BAYS; b++) begin : g_bay
      assign powered[b] = present_i[b];
    end
  endgenerate

  logic unused_bay0;
  assign unused_bay0 = present_i[0];

  always_comb begin
    pwr_o = '0;
    for (int unsigned b = 0; b < BAYS; b++) begin
      if (powered[b]) begin
        pwr_o[pwr5_pos(b)] = 1'b1;
        pwr_o[pwr3_pos(b)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  // set dominates acknowledge so a fresh event is never dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (ack_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/hs_evt_reg.sv
module hs_evt_reg
  import bay_regs_pkg::*;
#(
  parameter int unsigned WIDTH = EVT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic             ack_i,
  output logic [WIDTH-1:0] evt_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= (evt_o & ~clr_i) | set_i;
  end

  irq_latch i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (|set_i),
    .ack_i  (ack_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/bay_pwr_hotswap_regs.sv
module bay_pwr_hotswap_regs
  import bay_regs_pkg::*;
#(
  parameter int unsigned BAYS  = NUM_BAYS,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  localparam int unsigned EW   = BAYS + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [BAYS-1:0] bay_present_i,
  input  logic [BAYS-2:0] ins_evt_i,
  input  logic            sram_err_i,
  input  logic            mgmt_evt_i,
  output logic            ins_irq_o,
  output logic            mgmt_irq_o
);
  logic [DW-1:0] pwr_word;
  logic [DW-1:0] ctrl_q;
  logic [EW-1:0] evt_q;
  logic [EW-1:0] evt_set;
  logic [EW-1:0] evt_clr;
  logic          hit_evt;
  logic          hit_mgmt;
  logic [DW-1:0] rd_mux;

  assign hit_evt  = (addr_i == AW'(OFS_EVT))  && (rd_i || wr_i);
  assign hit_mgmt = (addr_i == AW'(OFS_MGMT)) && rd_i;

  bay_pwr_map #(.BAYS(BAYS), .WIDTH(DW)) i_pwr (
    .present_i (bay_present_i),
    .pwr_o     (pwr_word)
  );

  assign evt_set = {sram_err_i, ins_evt_i, 1'b0};
  assign evt_clr = (wr_i && addr_i == AW'(OFS_EVT)) ? wdata_i[EW-1:0] : '0;

  hs_evt_reg #(.WIDTH(EW)) i_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .ack_i  (hit_evt),
    .evt_o  (evt_q),
    .irq_o  (ins_irq_o)
  );

  irq_latch i_mgmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mgmt_evt_i),
    .ack_i  (hit_mgmt),
    .irq_o  (mgmt_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ctrl_q <= '0;
    else if (wr_i && addr_i == AW'(OFS_CTRL))   ctrl_q <= wdata_i;
  end

  always_comb begin
    case (addr_i)
      AW'(OFS_PWR):  rd_mux = pwr_word;
      AW'(OFS_MGMT): rd_mux = pwr_word & DW'(MGMT_MASK);
      AW'(OFS_CTRL): rd_mux = ctrl_q;
      AW'(OFS_EVT):  rd_mux = DW'(evt_q);
      AW'(OFS_ONES): rd_mux = '1;
      default:       rd_mux = '0;  // includes the error-enable offset
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/bay_regs_chk.sv
module bay_regs_chk
  import bay_regs_pkg::*;
#(
  parameter int unsigned BAYS = NUM_BAYS,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   addr_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic [BAYS-2:0] ins_evt_i,
  input logic            sram_err_i,
  input logic            mgmt_evt_i,
  input logic [DW-1:0]   rdata_o,
  input logic            ins_irq_o,
  input logic            mgmt_irq_o
);
  p_ins_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ins_evt_i || sram_err_i) |=> ins_irq_o);

  p_ins_irq_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && addr_i == AW'(OFS_EVT) && !(|ins_evt_i) && !sram_err_i)
    |=> !ins_irq_o);

  p_mgmt_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_evt_i |=> mgmt_irq_o);

  p_mgmt_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(OFS_MGMT) && !mgmt_evt_i) |=> !mgmt_irq_o);

  p_mgmt_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(OFS_MGMT)) |=> ((rdata_o & ~DW'(MGMT_MASK)) == '0));

  p_all_ones_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(OFS_ONES)) |=> (rdata_o == '1));

  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind bay_pwr_hotswap_regs bay_regs_chk #(.BAYS(BAYS), .AW(AW), .DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .ins_evt_i  (ins_evt_i),
  .sram_err_i (sram_err_i),
  .mgmt_evt_i (mgmt_evt_i),
  .rdata_o    (rdata_o),
  .ins_irq_o  (ins_irq_o),
  .mgmt_irq_o (mgmt_irq_o)
);

// File: tb/test_bay_pwr_hotswap_regs.sv
`timescale 1ns/1ps
module test_bay_pwr_hotswap_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  present = '0;
  logic [5:0]  ins_evt = '0;
  logic        sram_err = 1'b0, mgmt_evt = 1'b0;
  logic        ins_irq, mgmt_irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bay_pwr_hotswap_regs i_bay_pwr_hotswap_regs (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .rd_i (rd), .wr_i (wr),
    .wdata_i (wdata), .rdata_o (rdata), .bay_present_i (present),
    .ins_evt_i (ins_evt), .sram_err_i (sram_err), .mgmt_evt_i (mgmt_evt),
    .ins_irq_o (ins_irq), .mgmt_irq_o (mgmt_irq)
  );

  // {presence, expected 0x50 word, expected 0x40 word}
  localparam logic [70:0] VEC [10] = '{
    {7'b0000000, 32'h0000_0006, 32'h0000_0000},
    {7'b0000001, 32'h0000_0006, 32'h0000_0000},
    {7'b0000010, 32'h0000_0606, 32'h0000_0600},
    {7'b0000100, 32'h0000_6006, 32'h0000_6000},
    {7'b0001000, 32'h0600_0006, 32'h0600_0000},
    {7'b0010000, 32'h0006_0006, 32'h0006_0000},
    {7'b0100000, 32'h6000_0006, 32'h6000_0000},
    {7'b1000000, 32'h0060_0006, 32'h0060_0000},
    {7'b1111111, 32'h6666_6606, 32'h6666_6600},
    {7'b1010101, 32'h0066_6006, 32'h0066_6000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_evt(logic [5:0] slots, logic sram);
    @(negedge clk); ins_evt = slots; sram_err = sram;
    @(negedge clk); ins_evt = '0; sram_err = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 ins_irq", 32'(ins_irq), 32'h0);
    chk("R1 mgmt_irq", 32'(mgmt_irq), 32'h0);
    rst_n = 1'b1;
    rd_reg(8'h58, d); chk("R1 ctrl", d, 32'h0);
    rd_reg(8'h70, d); chk("R1 evt", d, 32'h0);

    // R2 / R8 table walk
    foreach (VEC[i]) begin
      present = VEC[i][70:64];
      rd_reg(8'h50, d); chk("R2 power word", d, VEC[i][63:32]);
      rd_reg(8'h40, d); chk("R8 masked word", d, VEC[i][31:0]);
    end

    // R2 rdata holds without a read
    repeat (3) @(negedge clk);
    chk("R2 hold", rdata, 32'h0066_6000);

    // R3 control word
    wr_reg(8'h58, 32'hA5C3_5A3C);
    rd_reg(8'h58, d); chk("R3 ctrl", d, 32'hA5C3_5A3C);

    // R11 write to power word ignored
    present = 7'b0000010;
    wr_reg(8'h50, 32'hFFFF_FFFF);
    rd_reg(8'h50, d); chk("R11 pwr ro", d, 32'h0000_0606);

    // R10 fixed offsets
    rd_reg(8'h48, d); chk("R10 ones", d, 32'hFFFF_FFFF);
    wr_reg(8'h78, 32'hFFFF_FFFF);
    rd_reg(8'h78, d); chk("R10 err-enable", d, 32'h0);
    rd_reg(8'h30, d); chk("R10 unmapped", d, 32'h0);

    // R4 / R7 slot 3 event, then acknowledge by read
    pulse_evt(6'b000100, 1'b0);
    chk("R7 irq set", 32'(ins_irq), 32'h1);
    rd_reg(8'h70, d); chk("R4 slot3", d, 32'h0000_0008);
    chk("R7 irq ack rd", 32'(ins_irq), 32'h0);
    pulse_evt(6'b000000, 1'b1);
    chk("R7 irq sram", 32'(ins_irq), 32'h1);
    rd_reg(8'h70, d); chk("R4 sram", d, 32'h0000_0088);

    // R5 W1C, R7 ack by write
    pulse_evt(6'b100000, 1'b0);
    wr_reg(8'h70, 32'h0000_0008);
    chk("R7 irq ack wr", 32'(ins_irq), 32'h0);
    rd_reg(8'h70, d); chk("R5 w1c", d, 32'h0000_00C0);

    // R6 event collides with clearing write
    @(negedge clk); addr = 8'h70; wdata = 32'hFF; wr = 1'b1; ins_evt = 6'b000001;
    @(negedge clk); wr = 1'b0; ins_evt = '0;
    chk("R6 irq kept", 32'(ins_irq), 32'h1);
    rd_reg(8'h70, d); chk("R6 evt kept", d, 32'h0000_0002);

    // R9 management interrupt
    @(negedge clk); mgmt_evt = 1'b1;
    @(negedge clk); mgmt_evt = 1'b0;
    chk("R9 mgmt set", 32'(mgmt_irq), 32'h1);
    @(negedge clk); addr = 8'h40; rd = 1'b1; mgmt_evt = 1'b1;
    @(negedge clk); rd = 1'b0; mgmt_evt = 1'b0;
    chk("R9 mgmt collide", 32'(mgmt_irq), 32'h1);
    rd_reg(8'h40, d);
    chk("R9 mgmt ack", 32'(mgmt_irq), 32'h0);
    chk("R8 masked bay1", d, 32'h0000_0600);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule